// File: doc/BRIEF.md
# Flash Protection Region Access Checker

This block sits in front of a flash controller and decides, for each flash access, whether the access may go ahead. It holds up to eight region descriptors. Each descriptor has an enable, a first and last 4 KB page, a set of restriction bits, one per access kind, and a region type. The type is taken from configuration inputs while reset is held, and nothing can change it afterwards. A request carries an address, an access kind and the address of the instruction now executing. One cycle later the block returns grant or deny, and it raises a violation pulse when the request is denied.

Software can rewrite the bounds, enable and restrictions of firmware-type regions through a small register port until it sets a lock bit. Two region types carry fixed rules:
- A one-time-programmable region never accepts an erase.
- A root-of-trust region enforces its restrictions only after software sets a done flag, and then only against code fetched from outside that region.

Top module: `fpr_checker`

## Requirements
- R1: An address hits a region when the region is enabled and the address page lies between the region's start page and end page, both included. A request that hits no enabled region is granted, whatever its kind.
- R2: Region bounds are held as 4 KB page numbers. The low 12 bits of the request address and of the fetch address never affect a decision.
- R3: While `rstN` is low, every descriptor loads from the `cfg*` inputs. The type codes are 0 for firmware, 1 for one-time-programmable and 2 for root-of-trust, and 3 behaves as firmware. No register write changes a type. The control readback shows the type in bits [6:5].
- R4: Register writes use the select codes 0 for start page, 1 for end page, 2 for control and 3 for global. A control write sets enable from data bit 0 and restrictions from data bits [4:1]. Once the lock is set (global write with data bit 0 = 1), descriptor writes are ignored until reset. The lock cannot be cleared except by reset.
- R5: Descriptor writes aimed at a one-time-programmable or root-of-trust region are ignored.
- R6: An erase that hits an enabled one-time-programmable region is denied, whatever its restriction bits and the done flag.
- R7: The restriction bits are bit 0 read, bit 1 write, bit 2 execute and bit 3 CRC, where 1 means denied. Erase obeys the write bit. The kind codes are 0 read, 1 write, 2 erase, 3 execute and 4 CRC. Codes 5 to 7 are denied in any region they hit.
- R8: A root-of-trust region's restrictions apply only when the done flag is set and the fetch page lies outside that region. Done is set by a global write with data bit 1 = 1, and only reset clears it. The global readback shows {done, lock} in bits [1:0].
- R9: When regions overlap, the request is denied if any hit region denies it.
- R10: The response for a request sampled at a clock edge is valid after that edge and lasts exactly one cycle. `violation` is high only together with a valid, denied response.
- R11: After reset, lock and done are clear and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; descriptors load from the cfg inputs while it is low |
| cfgType | input | 2*NUM_REGIONS | Region type codes loaded at reset |
| cfgEnable | input | NUM_REGIONS | Region enables loaded at reset |
| cfgStart | input | NUM_REGIONS*PAGE_W | Start pages loaded at reset |
| cfgEnd | input | NUM_REGIONS*PAGE_W | End pages loaded at reset |
| cfgRestrict | input | 4*NUM_REGIONS | Restriction bits loaded at reset |
| wrEn | input | 1 | Register write strobe |
| wrRegion | input | IDX_W | Region targeted by the write |
| wrSel | input | 2 | Field selected by the write |
| wrData | input | PAGE_W | Write data |
| rdRegion | input | IDX_W | Region to read back |
| rdSel | input | 2 | Field to read back |
| rdData | output | PAGE_W | Readback data (combinational) |
| reqValid | input | 1 | Request strobe |
| reqKind | input | 3 | Access kind code |
| reqAddr | input | ADDR_W | Access address |
| reqFetchAddr | input | ADDR_W | Address of the executing instruction |
| rspValid | output | 1 | Decision valid |
| rspGrant | output | 1 | Access granted |
| violation | output | 1 | One-cycle pulse on a denied request |

## Verification
Requests are sent at the first byte, the last byte and just past each region, and at addresses covered by no region or only by a disabled one. These patterns separate an inclusive page compare from an off-by-one compare, and show whether the enable is checked. Every kind is tried against regions that restrict only one kind, which shows that the kind-to-bit mapping is right and that erase follows the write bit. One range is covered by two overlapping regions with different restrictions, to show that any deny wins.

The root-of-trust region is probed with fetch addresses inside and outside it, both before and after done is set. The one-time-programmable regions receive erases that their restriction bits would otherwise allow. Writes made after the lock, writes aimed at fixed-type regions, and attempts to clear lock or done are each followed by readback, and also by requests whose outcome would flip if the write had taken effect.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [1:0] {
    RT_FW   = 2'd0,
    RT_OTP  = 2'd1,
    RT_ROT  = 2'd2,
    RT_RSVD = 2'd3
  } regionType_e;

  localparam logic [2:0] K_READ  = 3'd0;
  localparam logic [2:0] K_WRITE = 3'd1;
  localparam logic [2:0] K_ERASE = 3'd2;
  localparam logic [2:0] K_EXEC  = 3'd3;
  localparam logic [2:0] K_CRC   = 3'd4;

  localparam logic [1:0] SEL_START  = 2'd0;
  localparam logic [1:0] SEL_END    = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_GLOBAL = 2'd3;

  localparam int RES_RD  = 0;
  localparam int RES_WR  = 1;
  localparam int RES_EX  = 2;
  localparam int RES_CRC = 3;
  localparam int RES_W   = 4;

  typedef struct packed {
    logic loadCfg;
    logic reqLoad;
    logic wrStart;
    logic wrEnd;
    logic wrCtrl;
  } dpStrobe_t;

endpackage

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
  import fpr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [IDX_W-1:0]            wrRegion,
  input  logic [1:0]                  wrSel,
  input  logic [1:0]                  wrFlags,
  input  logic [NUM_REGIONS-1:0][1:0] regionType,
  input  logic                        reqValid,
  output dpStrobe_t                   strb,
  output logic                        lockQ,
  output logic                        doneQ
);

  logic targetFw;
  logic descWrite;
  logic globalWrite;

  always_comb begin
    targetFw = 1'b0;
    if (int'(wrRegion) < NUM_REGIONS) begin
      targetFw = (regionType[wrRegion] != RT_OTP) && (regionType[wrRegion] != RT_ROT);
    end
  end

  assign descWrite   = rstN && wrEn && !lockQ && targetFw;
  assign globalWrite = rstN && wrEn && (wrSel == SEL_GLOBAL);

  always_comb begin
    strb         = '0;
    strb.loadCfg = !rstN;
    strb.reqLoad = rstN && reqValid;
    strb.wrStart = descWrite && (wrSel == SEL_START);
    strb.wrEnd   = descWrite && (wrSel == SEL_END);
    strb.wrCtrl  = descWrite && (wrSel == SEL_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (globalWrite) begin
      if (wrFlags[0]) lockQ <= 1'b1;
      if (wrFlags[1]) doneQ <= 1'b1;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> doneQ); // R8

endmodule

// File: rtl/fpr_dp.sv
module fpr_dp
  import fpr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3,
  parameter int PAGE_W      = 12
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrobe_t                          strb,
  input  logic [IDX_W-1:0]                   wrRegion,
  input  logic [PAGE_W-1:0]                  wrData,
  input  logic [NUM_REGIONS-1:0][1:0]        cfgType,
  input  logic [NUM_REGIONS-1:0]             cfgEnable,
  input  logic [NUM_REGIONS-1:0][PAGE_W-1:0] cfgStart,
  input  logic [NUM_REGIONS-1:0][PAGE_W-1:0] cfgEnd,
  input  logic [NUM_REGIONS-1:0][RES_W-1:0]  cfgRestrict,
  input  logic [2:0]                         reqKind,
  input  logic [PAGE_W-1:0]                  reqPage,
  input  logic [PAGE_W-1:0]                  reqFetchPage,
  input  logic                               lockQ,
  input  logic                               doneQ,
  input  logic [IDX_W-1:0]                   rdRegion,
  input  logic [1:0]                         rdSel,
  output logic [NUM_REGIONS-1:0][1:0]        regionType,
  output logic [PAGE_W-1:0]                  rdData,
  output logic                               rspValid,
  output logic                               rspGrant,
  output logic                               violation
);

  logic [NUM_REGIONS-1:0]             enQ;
  logic [NUM_REGIONS-1:0][PAGE_W-1:0] startQ;
  logic [NUM_REGIONS-1:0][PAGE_W-1:0] endQ;
  logic [NUM_REGIONS-1:0][RES_W-1:0]  resQ;
  logic [NUM_REGIONS-1:0][1:0]        typeQ;

  logic              validQ;
  logic [2:0]        kindQ;
  logic [PAGE_W-1:0] pageQ;
  logic [PAGE_W-1:0] fetchPageQ;

  logic [NUM_REGIONS-1:0] hitVec;
  logic [NUM_REGIONS-1:0] denyVec;
  logic [NUM_REGIONS-1:0] otpHitVec;

  assign regionType = typeQ;

  // request register
  always_ff @(posedge clk) begin
    if (strb.loadCfg) begin
      validQ     <= 1'b0;
      kindQ      <= K_READ;
      pageQ      <= '0;
      fetchPageQ <= '0;
    end else begin
      validQ <= strb.reqLoad;
      if (strb.reqLoad) begin
        kindQ      <= reqKind;
        pageQ      <= reqPage;
        fetchPageQ <= reqFetchPage;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic selHere;
    logic fetchInside;
    logic gateOn;
    logic kindBlocked;

    assign selHere = (wrRegion == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (strb.loadCfg) begin
        typeQ[g]  <= cfgType[g];
        enQ[g]    <= cfgEnable[g];
        startQ[g] <= cfgStart[g];
        endQ[g]   <= cfgEnd[g];
        resQ[g]   <= cfgRestrict[g];
      end else if (selHere) begin
        if (strb.wrStart) startQ[g] <= wrData;
        if (strb.wrEnd)   endQ[g]   <= wrData;
        if (strb.wrCtrl) begin
          enQ[g]  <= wrData[0];
          resQ[g] <= wrData[RES_W:1];
        end
      end
    end

    assign hitVec[g]      = enQ[g] && (pageQ >= startQ[g]) && (pageQ <= endQ[g]);
    assign fetchInside    = (fetchPageQ >= startQ[g]) && (fetchPageQ <= endQ[g]);
    assign gateOn         = (typeQ[g] != RT_ROT) || (doneQ && !fetchInside);
    assign otpHitVec[g]   = hitVec[g] && (typeQ[g] == RT_OTP);

    always_comb begin
      unique case (kindQ)
        K_READ:           kindBlocked = resQ[g][RES_RD];
        K_WRITE, K_ERASE: kindBlocked = resQ[g][RES_WR];
        K_EXEC:           kindBlocked = resQ[g][RES_EX];
        K_CRC:            kindBlocked = resQ[g][RES_CRC];
        default:          kindBlocked = 1'b1;
      endcase
    end

    assign denyVec[g] = hitVec[g] &&
                        ((otpHitVec[g] && (kindQ == K_ERASE)) || (gateOn && kindBlocked));
  end

  assign rspValid  = validQ;
  assign rspGrant  = validQ && !(|denyVec);
  assign violation = validQ && (|denyVec);

  // readback
  always_comb begin
    rdData = '0;
    if (rdSel == SEL_GLOBAL) begin
      rdData = PAGE_W'({doneQ, lockQ});
    end else if (int'(rdRegion) < NUM_REGIONS) begin
      unique case (rdSel)
        SEL_START: rdData = startQ[rdRegion];
        SEL_END:   rdData = endQ[rdRegion];
        default:   rdData = PAGE_W'({typeQ[rdRegion], resQ[rdRegion], enQ[rdRegion]});
      endcase
    end
  end

  AST_TYPE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(typeQ)); // R3
  AST_LOCKED_DESC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> ($stable(enQ) && $stable(startQ) && $stable(endQ) && $stable(resQ))); // R4
  AST_OTP_NO_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (kindQ == K_ERASE) && (|otpHitVec)) |-> !rspGrant); // R6
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    strb.reqLoad |=> rspValid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.reqLoad |=> !rspValid); // R10
  AST_VIOL_WITH_DENY: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (rspValid && !rspGrant)); // R10

endmodule

// File: rtl/fpr_checker.sv
module fpr_checker
  import fpr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 24,
  parameter int ALIGN_BITS  = 12,
  parameter int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  parameter int PAGE_W      = ADDR_W - ALIGN_BITS
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [2*NUM_REGIONS-1:0]        cfgType,
  input  logic [NUM_REGIONS-1:0]          cfgEnable,
  input  logic [NUM_REGIONS*PAGE_W-1:0]   cfgStart,
  input  logic [NUM_REGIONS*PAGE_W-1:0]   cfgEnd,
  input  logic [4*NUM_REGIONS-1:0]        cfgRestrict,
  input  logic                            wrEn,
  input  logic [IDX_W-1:0]                wrRegion,
  input  logic [1:0]                      wrSel,
  input  logic [PAGE_W-1:0]               wrData,
  input  logic [IDX_W-1:0]                rdRegion,
  input  logic [1:0]                      rdSel,
  output logic [PAGE_W-1:0]               rdData,
  input  logic                            reqValid,
  input  logic [2:0]                      reqKind,
  input  logic [ADDR_W-1:0]               reqAddr,
  input  logic [ADDR_W-1:0]               reqFetchAddr,
  output logic                            rspValid,
  output logic                            rspGrant,
  output logic                            violation
);

  dpStrobe_t                          strb;
  logic                               lockQ;
  logic                               doneQ;
  logic [NUM_REGIONS-1:0][1:0]        regionType;
  logic [NUM_REGIONS-1:0][1:0]        cfgTypeA;
  logic [NUM_REGIONS-1:0][PAGE_W-1:0] cfgStartA;
  logic [NUM_REGIONS-1:0][PAGE_W-1:0] cfgEndA;
  logic [NUM_REGIONS-1:0][RES_W-1:0]  cfgResA;
  logic                               unusedLowBits;

  assign cfgTypeA  = cfgType;
  assign cfgStartA = cfgStart;
  assign cfgEndA   = cfgEnd;
  assign cfgResA   = cfgRestrict;
  assign unusedLowBits = ^{reqAddr[ALIGN_BITS-1:0], reqFetchAddr[ALIGN_BITS-1:0]};

  fpr_ctrl #(
    .NUM_REGIONS(NUM_REGIONS),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrRegion  (wrRegion),
    .wrSel     (wrSel),
    .wrFlags   (wrData[1:0]),
    .regionType(regionType),
    .reqValid  (reqValid),
    .strb      (strb),
    .lockQ     (lockQ),
    .doneQ     (doneQ)
  );

  fpr_dp #(
    .NUM_REGIONS(NUM_REGIONS),
    .IDX_W      (IDX_W),
    .PAGE_W     (PAGE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrRegion    (wrRegion),
    .wrData      (wrData),
    .cfgType     (cfgTypeA),
    .cfgEnable   (cfgEnable),
    .cfgStart    (cfgStartA),
    .cfgEnd      (cfgEndA),
    .cfgRestrict (cfgResA),
    .reqKind     (reqKind),
    .reqPage     (reqAddr[ADDR_W-1:ALIGN_BITS]),
    .reqFetchPage(reqFetchAddr[ADDR_W-1:ALIGN_BITS]),
    .lockQ       (lockQ),
    .doneQ       (doneQ),
    .rdRegion    (rdRegion),
    .rdSel       (rdSel),
    .regionType  (regionType),
    .rdData      (rdData),
    .rspValid    (rspValid),
    .rspGrant    (rspGrant),
    .violation   (violation)
  );

endmodule

// File: tb/fpr_checker_tb.sv
module fpr_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int AW = 24;
  localparam int PW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NR-1:0][1:0]    cfgType;
  logic [NR-1:0]         cfgEnable;
  logic [NR-1:0][PW-1:0] cfgStart;
  logic [NR-1:0][PW-1:0] cfgEnd;
  logic [NR-1:0][3:0]    cfgRestrict;
  logic          wrEn = 1'b0;
  logic [2:0]    wrRegion = '0;
  logic [1:0]    wrSel = '0;
  logic [PW-1:0] wrData = '0;
  logic [2:0]    rdRegion = '0;
  logic [1:0]    rdSel = '0;
  logic [PW-1:0] rdData;
  logic          reqValid = 1'b0;
  logic [2:0]    reqKind = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [AW-1:0] reqFetchAddr = '0;
  logic rspValid, rspGrant, violation;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  bit    expQ[$];
  string tagQ[$];

  // bench model state
  bit [NR-1:0]         mEn;
  bit [NR-1:0][PW-1:0] mStart, mEnd;
  bit [NR-1:0][3:0]    mRes;
  bit [NR-1:0][1:0]    mType;
  bit mLock, mDone;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpr_checker u_dut (
    .clk(clk), .rstN(rstN),
    .cfgType(cfgType), .cfgEnable(cfgEnable), .cfgStart(cfgStart),
    .cfgEnd(cfgEnd), .cfgRestrict(cfgRestrict),
    .wrEn(wrEn), .wrRegion(wrRegion), .wrSel(wrSel), .wrData(wrData),
    .rdRegion(rdRegion), .rdSel(rdSel), .rdData(rdData),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqFetchAddr(reqFetchAddr),
    .rspValid(rspValid), .rspGrant(rspGrant), .violation(violation)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit inPages(bit [PW-1:0] p, bit [PW-1:0] s, bit [PW-1:0] e);
    return (p >= s) && (p <= e);
  endfunction

  function automatic bit modelGrant(int kind, bit [AW-1:0] a, bit [AW-1:0] f);
    bit deny = 0;
    for (int i = 0; i < NR; i++) begin
      if (mEn[i] && inPages(a[AW-1:12], mStart[i], mEnd[i])) begin
        bit applies, blk;
        if (mType[i] == 2'd1 && kind == 2) deny = 1;
        applies = (mType[i] != 2'd2) || (mDone && !inPages(f[AW-1:12], mStart[i], mEnd[i]));
        case (kind)
          0:       blk = mRes[i][0];
          1, 2:    blk = mRes[i][1];
          3:       blk = mRes[i][2];
          4:       blk = mRes[i][3];
          default: blk = 1;
        endcase
        if (applies && blk) deny = 1;
      end
    end
    return !deny;
  endfunction

  task automatic loadModel();
    mEn = cfgEnable; mStart = cfgStart; mEnd = cfgEnd;
    mRes = cfgRestrict; mType = cfgType; mLock = 0; mDone = 0;
  endtask

  task automatic quiet();
    reqValid = 0; wrEn = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); quiet();
    end
  endtask

  // driver: issue a request and push the expected decision
  task automatic req(int kind, bit [AW-1:0] a, bit [AW-1:0] f, string tag);
    @(negedge clk); quiet();
    reqValid = 1; reqKind = 3'(kind); reqAddr = a; reqFetchAddr = f;
    expQ.push_back(modelGrant(kind, a, f));
    tagQ.push_back(tag);
  endtask

  task automatic regWrite(int region, int sel, bit [PW-1:0] d);
    @(negedge clk); quiet();
    wrEn = 1; wrRegion = 3'(region); wrSel = 2'(sel); wrData = d;
    if (sel == 3) begin
      if (d[0]) mLock = 1;
      if (d[1]) mDone = 1;
    end else if (!mLock && mType[region] != 2'd1 && mType[region] != 2'd2) begin
      if (sel == 0) mStart[region] = d;
      else if (sel == 1) mEnd[region] = d;
      else begin mEn[region] = d[0]; mRes[region] = d[4:1]; end
    end
  endtask

  task automatic readBack(int region, int sel, string tag);
    bit [PW-1:0] exp;
    @(negedge clk); quiet();
    rdRegion = 3'(region); rdSel = 2'(sel);
    if (sel == 3)      exp = PW'({mDone, mLock});
    else if (sel == 0) exp = mStart[region];
    else if (sel == 1) exp = mEnd[region];
    else               exp = PW'({mType[region], mRes[region], mEn[region]});
    #1;
    check(tag, 32'(rdData), 32'(exp));
  endtask

  task automatic doReset();
    @(negedge clk); quiet();
    rstN = 0;
    expQ.delete(); tagQ.delete();
    repeat (3) @(negedge clk);
    check("R10 no response in reset", {31'd0, rspValid}, 32'd0);
    rstN = 1;
    loadModel();
  endtask

  // monitor: pop and compare as responses appear
  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid) begin
        if (expQ.size() == 0) begin
          nCmp++; nBad++;
          $display("FAIL R10 unexpected response: actual 1 expected 0");
        end else begin
          bit e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, {31'd0, rspGrant}, {31'd0, e});
          check({t, " violation"}, {31'd0, violation}, {31'd0, !e});
        end
      end else if (violation) begin
        nCmp++; nBad++;
        $display("FAIL R10 violation without response: actual 1 expected 0");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    // types: 0 fw, 1 otp, 2 rot
    cfgType     = '0; cfgEnable = '0; cfgStart = '0; cfgEnd = '0; cfgRestrict = '0;
    cfgType[0] = 2'd0; cfgEnable[0] = 1; cfgStart[0] = 12'h010; cfgEnd[0] = 12'h01F; cfgRestrict[0] = 4'b0000;
    cfgType[1] = 2'd1; cfgEnable[1] = 1; cfgStart[1] = 12'h020; cfgEnd[1] = 12'h02F; cfgRestrict[1] = 4'b0000;
    cfgType[2] = 2'd2; cfgEnable[2] = 1; cfgStart[2] = 12'h030; cfgEnd[2] = 12'h03F; cfgRestrict[2] = 4'b1111;
    cfgType[3] = 2'd0; cfgEnable[3] = 0; cfgStart[3] = 12'h040; cfgEnd[3] = 12'h04F; cfgRestrict[3] = 4'b1111;
    cfgType[4] = 2'd0; cfgEnable[4] = 1; cfgStart[4] = 12'h050; cfgEnd[4] = 12'h05F; cfgRestrict[4] = 4'b0010;
    cfgType[5] = 2'd3; cfgEnable[5] = 1; cfgStart[5] = 12'h058; cfgEnd[5] = 12'h060; cfgRestrict[5] = 4'b0001;
    cfgType[6] = 2'd1; cfgEnable[6] = 1; cfgStart[6] = 12'h070; cfgEnd[6] = 12'h070; cfgRestrict[6] = 4'b0100;
    loadModel();
    repeat (3) @(negedge clk);
    check("R11 no response during reset", {31'd0, rspValid}, 32'd0);
    rstN = 1;

    // R11 / R3 reset state
    readBack(0, 3, "R11 lock and done clear");
    readBack(2, 0, "R3 start loaded from cfg");
    readBack(2, 2, "R3 rot type and ctrl loaded");
    readBack(5, 2, "R3 reserved type loaded");

    // R1 / R2 boundaries in region 0 (open)
    req(0, 24'h010000, 24'h000000, "R1 first byte granted");
    req(1, 24'h01FFFF, 24'h000000, "R2 last byte granted");
    req(4, 24'h080123, 24'h000000, "R1 no region granted");
    req(5, 24'h090000, 24'h000000, "R1 unknown kind outside regions granted");
    req(1, 24'h040000, 24'h000000, "R1 disabled region ignored");
    req(5, 24'h010800, 24'h000000, "R7 unknown kind inside region denied");

    // R7 per-kind restriction, region 4 blocks write
    req(1, 24'h050000, 24'h000000, "R7 write blocked");
    req(2, 24'h050FFF, 24'h000000, "R7 erase follows write bit");
    req(0, 24'h051000, 24'h000000, "R7 read allowed");
    req(3, 24'h05F000, 24'h000000, "R7 exec allowed");
    req(0, 24'h04FFFF, 24'h000000, "R1 page below region");
    // R9 overlap 0x58..0x5F: region 4 blocks write, region 5 blocks read
    req(0, 24'h058000, 24'h000000, "R9 overlap read denied");
    req(1, 24'h05C000, 24'h000000, "R9 overlap write denied");
    req(4, 24'h05C000, 24'h000000, "R9 overlap crc granted");
    req(0, 24'h060FFF, 24'h000000, "R1 end page inclusive read denied");
    req(0, 24'h061000, 24'h000000, "R1 page past end granted");
    idle(2);

    // R6 one-time-programmable
    req(2, 24'h020000, 24'h000000, "R6 erase denied despite open bits");
    req(1, 24'h02F000, 24'h000000, "R6 write granted");
    req(2, 24'h070ABC, 24'h000000, "R6 erase denied small otp");
    req(3, 24'h070000, 24'h000000, "R7 exec restricted in otp");
    req(0, 24'h070000, 24'h000000, "R7 read allowed in otp");

    // R8 root-of-trust before done
    req(0, 24'h030000, 24'h010000, "R8 before done granted");
    req(1, 24'h03F000, 24'h000000, "R8 before done write granted");
    regWrite(0, 3, 12'h002);
    req(0, 24'h030000, 24'h010000, "R8 outside fetch denied");
    req(4, 24'h031000, 24'h000000, "R8 crc outside fetch denied");
    req(0, 24'h030000, 24'h030100, "R8 inside fetch granted");
    req(3, 24'h032000, 24'h03FFFF, "R8 inside fetch last page granted");
    req(2, 24'h020000, 24'h020000, "R6 otp erase with done");
    idle(2);

    // R4 reprogram region 0 then lock
    regWrite(0, 2, 12'h003);            // enable, read blocked
    regWrite(0, 0, 12'h011);
    regWrite(0, 1, 12'h012);
    req(0, 24'h011000, 24'h000000, "R4 new restriction applied");
    req(0, 24'h010000, 24'h000000, "R4 new start applied");
    req(0, 24'h013000, 24'h000000, "R4 new end applied");
    readBack(0, 2, "R4 ctrl readback");
    readBack(0, 1, "R4 end readback");
    // R5 writes to fixed-type regions
    regWrite(1, 2, 12'h000);
    regWrite(2, 0, 12'h100);
    req(2, 24'h020000, 24'h000000, "R5 otp disable ignored");
    readBack(1, 2, "R5 otp ctrl unchanged");
    readBack(2, 0, "R5 rot start unchanged");
    // R3 type bits in ctrl write ignored
    regWrite(3, 2, 12'h061);
    readBack(3, 2, "R3 type not writable");
    // lock
    regWrite(0, 3, 12'h001);
    regWrite(0, 2, 12'h001);
    regWrite(0, 0, 12'h010);
    req(0, 24'h011000, 24'h000000, "R4 locked ctrl write ignored");
    req(0, 24'h010000, 24'h000000, "R4 locked start write ignored");
    readBack(0, 2, "R4 locked ctrl readback");
    readBack(0, 0, "R4 locked start readback");
    regWrite(0, 3, 12'h000);
    readBack(0, 3, "R8 done and lock stay set");

    // R10 back-to-back requests
    req(1, 24'h050000, 24'h000000, "R10 burst deny");
    req(0, 24'h050000, 24'h000000, "R10 burst grant");
    req(1, 24'h050000, 24'h000000, "R10 burst deny again");
    idle(3);
    check("R10 queue drained", 32'(expQ.size()), 32'd0);

    // R11 reset restores configuration
    doReset();
    readBack(0, 3, "R11 lock and done cleared by reset");
    readBack(0, 0, "R11 start reloaded");
    req(0, 24'h030000, 24'h010000, "R11 done cleared rot open");
    req(0, 24'h010000, 24'h000000, "R11 region 0 reloaded");
    idle(3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule